// File: doc/BRIEF.md
# Eight-Bit Addressable Latch and One-of-Eight Demultiplexer

This block holds eight single-bit storage cells that share one serial data input and a three-bit select. Two active-low controls, a write strobe and a wipe input, pick one of four modes between them. In the first mode the data input is written into one selected cell. In the second mode every cell keeps its value. In the third mode the block works as a stateless one-of-eight steering element. In the fourth mode everything is forced low. All eight cell values are brought out as parallel active-high outputs. The block can load a word one bit at a time, so it works as a serial-to-parallel converter. It can also spread a single signal across eight lines.

The block is modelled for synthesis as clocked logic. Every input is sampled on the rising edge of the system clock, and the outputs are registered, so the effect of a sampled mode appears one cycle later. A sticky misuse flag catches a select that changes between two consecutive write-mode samples. Such a change would hit the wrong cell in an asynchronous build. An asynchronous active-low reset is released synchronously inside the block. This reset clears the cells, the outputs and the flag.

Top module: `alatch_top`

## Requirements
- R1: After reset is released, all eight outputs `q` and the flag `addr_err` read 0.
- R2: A sample with `wr_n`=0 and `wipe_n`=1 writes `din` into cell `sel`, and `q[sel]` shows it one cycle later. All other cells keep their values.
- R3: A sample with `wr_n`=1 and `wipe_n`=1 holds every cell. `din` and `sel` have no effect, and `q` shows the stored word.
- R4: A sample with `wr_n`=0 and `wipe_n`=0 drives `q[sel]` to `din` one cycle later and drives the other seven outputs to 0.
- R5: A sample with `wr_n`=1 and `wipe_n`=0 drives all outputs to 0 one cycle later, whatever `sel` and `din` are, and empties every cell.
- R6: Demultiplex mode empties the cells. A hold-mode sample that follows it shows all outputs at 0.
- R7: The select is plain binary. Value k addresses output bit `q[k]`, so 0 maps to `q[0]` and 7 maps to `q[7]`.
- R8: `addr_err` goes to 1 one cycle after a write-mode sample whose `sel` differs from the `sel` of the write-mode sample just before it.
- R9: Once set, `addr_err` stays 1 through every mode, including wipe. Only `rst_n` clears it.
- R10: A `sel` change never sets `addr_err` when either of the two samples involved is not write mode. This includes a change on the same sample on which write mode starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_n | input | 1 | Active-low write strobe |
| wipe_n | input | 1 | Active-low common wipe |
| din | input | 1 | Single data bit |
| sel | input | 3 | Binary select of the target cell/output |
| q | output | 8 | Parallel active-high outputs, bit k is cell k |
| addr_err | output | 1 | Sticky flag: select changed between consecutive write samples |

## Verification
A stuck or mis-steered storage cell shows on its own output bit in the cycle after the write that should have set it. A cell that fails to hold shows in the cycle after a hold sample. A demultiplex or wipe that leaves a cell dirty stays hidden while demultiplexing and becomes visible only on the next hold-mode sample, so the bench follows every demultiplex run with a hold sample. A wrong select-history register in the flag logic shows as `addr_err` rising one cycle after a write sample that should not have set it, or as `addr_err` failing to rise. Since the flag is sticky, a single false trigger stays visible for the rest of the run.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_WIPE  = 2'd3
  } alatch_mode_e;

  function automatic alatch_mode_e decode_mode(input logic wr_n, input logic wipe_n);
    alatch_mode_e m;
    case ({wr_n, wipe_n})
      2'b01:   m = MODE_WRITE;
      2'b11:   m = MODE_HOLD;
      2'b00:   m = MODE_DEMUX;
      default: m = MODE_WIPE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alatch_rst_sync.sv
module alatch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import alatch_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int AW = $clog2(NBITS)
) (
  input  logic              wr_n,
  input  logic              wipe_n,
  input  logic [AW-1:0]     sel,
  output alatch_mode_e      mode,
  output logic [NBITS-1:0]  hit
);

  always_comb begin
    mode = decode_mode(wr_n, wipe_n);
  end

  for (genvar k = 0; k < NBITS; k++) begin : g_hit
    assign hit[k] = (sel == AW'(k));
  end

  always_comb begin
    assert ($onehot0(hit)) else $error("AST_SEL_ONEHOT"); // R7
  end

endmodule

// File: rtl/alatch_bitcell.sv
module alatch_bitcell
  import alatch_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  alatch_mode_e mode,
  input  logic         hit,
  input  logic         din,
  output logic         cell_q,
  output logic         out_q
);

  logic cell_d;
  logic out_d;
  logic cell_en;

  // next state
  always_comb begin
    case (mode)
      MODE_WRITE: cell_d = hit ? din : cell_q;
      MODE_HOLD:  cell_d = cell_q;
      default:    cell_d = 1'b0;
    endcase
    cell_en = (mode != MODE_HOLD);
    out_d   = (mode == MODE_DEMUX) ? (hit & din) : cell_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= 1'b0;
    end else if (cell_en) begin
      cell_q <= cell_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  AST_WIPE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WIPE) |=> (!out_q && !cell_q)) else $error("AST_WIPE_LOW"); // R5
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(cell_q)) else $error("AST_HOLD_KEEP"); // R3
  AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE && !hit) |=> $stable(cell_q)) else $error("AST_WRITE_OTHERS"); // R2
  AST_DEMUX_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEMUX && !hit) |=> !out_q) else $error("AST_DEMUX_UNSEL"); // R4
  AST_DEMUX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEMUX) |=> !cell_q) else $error("AST_DEMUX_EMPTY"); // R6

endmodule

// File: rtl/alatch_guard.sv
module alatch_guard
  import alatch_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  alatch_mode_e  mode,
  input  logic [AW-1:0] sel,
  output logic          flag_q
);

  logic [AW-1:0] prev_sel_q;
  logic          prev_wr_q;
  logic          is_wr;
  logic          flag_d;

  always_comb begin
    is_wr  = (mode == MODE_WRITE);
    flag_d = flag_q | (is_wr & prev_wr_q & (sel != prev_sel_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_q <= '0;
      prev_wr_q  <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      prev_sel_q <= sel;
      prev_wr_q  <= is_wr;
      flag_q     <= flag_d;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q) else $error("AST_FLAG_STICKY"); // R9
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !is_wr) |=> !flag_q) else $error("AST_FLAG_QUIET"); // R10

endmodule

// File: rtl/alatch_top.sv
module alatch_top
  import alatch_pkg::*;
#(
  parameter int NBITS = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             wipe_n,
  input  logic             din,
  input  logic [AW-1:0]    sel,
  output logic [NBITS-1:0] q,
  output logic             addr_err
);

  logic             rst_sync_n;
  alatch_mode_e     mode;
  logic [NBITS-1:0] hit;
  logic [NBITS-1:0] cells;

  alatch_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alatch_mode_dec #(.NBITS(NBITS)) u_dec (
    .wr_n   (wr_n),
    .wipe_n (wipe_n),
    .sel    (sel),
    .mode   (mode),
    .hit    (hit)
  );

  for (genvar k = 0; k < NBITS; k++) begin : g_cell
    alatch_bitcell u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .mode   (mode),
      .hit    (hit[k]),
      .din    (din),
      .cell_q (cells[k]),
      .out_q  (q[k])
    );
  end

  alatch_guard #(.AW(AW)) u_guard (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mode   (mode),
    .sel    (sel),
    .flag_q (addr_err)
  );

  AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_DEMUX) |=> $onehot0(q)) else $error("AST_DEMUX_ONEHOT"); // R4
  AST_HOLD_SHOWS_CELLS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_HOLD) |=> (q == cells)) else $error("AST_HOLD_SHOWS_CELLS"); // R3
  AST_WRITE_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_WRITE) |=> ($countones(cells ^ $past(cells)) <= 1)) else $error("AST_WRITE_COUNT"); // R2

endmodule

// File: tb/alatch_top_tb.sv
module alatch_top_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_n, wipe_n, din;
  logic [2:0] sel;
  logic [7:0] q;
  logic       addr_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] exp_q_fifo [$];
  logic       exp_f_fifo [$];
  string      tag_fifo   [$];

  // reference model state
  logic [7:0] m_cells;
  logic       m_flag;
  logic       m_prev_wr;
  logic [2:0] m_prev_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  alatch_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wipe_n(wipe_n),
    .din(din), .sel(sel), .q(q), .addr_err(addr_err)
  );

  task automatic check(input string tag, input logic [7:0] eq, input logic ef);
    total++;
    if (q !== eq || addr_err !== ef) begin
      bad++;
      $display("FAIL %s: q=%b addr_err=%b expected q=%b addr_err=%b", tag, q, addr_err, eq, ef);
    end
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q_fifo.size() > 0) begin
        check(tag_fifo.pop_front(), exp_q_fifo.pop_front(), exp_f_fifo.pop_front());
      end
    end
  end

  task automatic model_reset();
    m_cells = '0; m_flag = 1'b0; m_prev_wr = 1'b0; m_prev_sel = '0;
  endtask

  // driver: applies one sample and queues the expected result
  task automatic drive(input logic w, input logic c, input logic d,
                       input logic [2:0] a, input string tag);
    logic [7:0] eq;
    @(negedge clk);
    wr_n = w; wipe_n = c; din = d; sel = a;
    case ({w, c})
      2'b01: begin
        if (m_prev_wr && a != m_prev_sel) m_flag = 1'b1;
        m_cells[a] = d;
        eq = m_cells;
      end
      2'b11: eq = m_cells;
      2'b00: begin
        m_cells = '0;
        eq = '0;
        eq[a] = d;
      end
      default: begin
        m_cells = '0;
        eq = '0;
      end
    endcase
    m_prev_wr  = ({w, c} == 2'b01);
    m_prev_sel = a;
    @(posedge clk);
    #1;
    exp_q_fifo.push_back(eq);
    exp_f_fifo.push_back(m_flag);
    tag_fifo.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_n = 1'b1; wipe_n = 1'b1; din = 1'b0; sel = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: q=%b addr_err=%b expected run to finish", q, addr_err);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_n = 1'b1; wipe_n = 1'b1; din = 1'b0; sel = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", 8'h00, 1'b0);

    // R2/R7/R10: write each bit, changing the select only in hold samples
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 1'b1, 1'b0, 3'(k), "R10 select moved in hold");
      drive(1'b0, 1'b1, (k % 2 == 0), 3'(k), "R2 R7 addressed write");
    end
    // R3: hold ignores din and sel
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 1'b1, k[0], 3'(7 - k), "R3 hold ignores inputs");
    end
    // R2: repeated writes at one select, toggling data
    drive(1'b0, 1'b1, 1'b1, 3'd1, "R2 set bit 1");
    drive(1'b0, 1'b1, 1'b0, 3'd1, "R2 clear bit 1");
    drive(1'b1, 1'b1, 1'b1, 3'd6, "R3 hold after writes");

    // R4/R7: demultiplex every select with data 1 then data 0
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, 1'b0, 1'b1, 3'(k), "R4 R7 demux high");
    end
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, 1'b0, 1'b0, 3'(k), "R4 demux low");
    end
    drive(1'b1, 1'b1, 1'b1, 3'd2, "R6 hold after demux");

    // R5: wipe a populated word under varied select/data
    drive(1'b1, 1'b1, 1'b0, 3'd7, "R10 move select");
    drive(1'b0, 1'b1, 1'b1, 3'd7, "R2 write bit 7");
    drive(1'b1, 1'b1, 1'b0, 3'd0, "R10 move select");
    drive(1'b0, 1'b1, 1'b1, 3'd0, "R2 write bit 0");
    drive(1'b1, 1'b0, 1'b1, 3'd5, "R5 wipe");
    drive(1'b1, 1'b0, 1'b0, 3'd3, "R5 wipe again");
    drive(1'b1, 1'b1, 1'b0, 3'd3, "R5 hold after wipe");

    // R10: write mode entered on the same sample the select changes
    drive(1'b0, 1'b1, 1'b1, 3'd4, "R10 entry with new select");
    drive(1'b0, 1'b1, 1'b1, 3'd4, "R8 same select no flag");
    drive(1'b0, 1'b1, 1'b1, 3'd5, "R8 select changed during write");
    drive(1'b1, 1'b0, 1'b0, 3'd0, "R9 flag survives wipe");
    drive(1'b0, 1'b0, 1'b1, 3'd2, "R9 flag survives demux");
    drive(1'b1, 1'b1, 1'b0, 3'd2, "R9 flag survives hold");
    repeat (2) @(negedge clk);

    do_reset();
    check("R9 R1 reset clears flag", 8'h00, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 3'd3, "R2 after reset");
    drive(1'b0, 1'b0, 1'b1, 3'd6, "R4 after reset");
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule